// File: doc/BRIEF.md
# Triple-Network Frame Replicator and Duplicate Filter

This block sits between a frame source/sink and three identical, independent networks, here called A, B and C. On the send side it takes one frame descriptor per handshake and presents three identical copies to the three network ports in the same clock cycle. A descriptor is taken only when all three ports can take it, so the copies always leave together.

On the receive side, each network port delivers a header made of a virtual link number and a sequence number. The block keeps the last accepted sequence number for each virtual link. It passes up only the first copy of each frame to arrive, whichever network that copy came from. Later copies with a number it has already delivered, or an older one, are dropped. If one network loses a frame, the copy from another network is the one delivered. Two counters record how many frames were delivered and how many copies were thrown away. Payload storage and integrity checking belong to other blocks.

Top module: `trinet_redundancy`

## Requirements
- R1: `tx_ready` is high exactly when all three network send ports signal ready, whatever the value of `tx_valid`.
- R2: When `tx_valid` and `tx_ready` are both high, all three network send ports show valid in that same cycle and carry a copy of `tx_desc`. When the two are not both high, no network send port shows valid.
- R3: After reset no virtual link has a history, so the first frame seen on a virtual link is delivered whatever its sequence number. `rx_valid` and both counters are zero out of reset.
- R4: A frame that is accepted appears on `rx_valid`, `rx_vl` and `rx_seq` exactly one clock after it is presented. `rx_port` gives the network it arrived on, encoded A=0, B=1, C=2.
- R5: With SEQ_W-bit numbers, let g = (new − last) mod 2^SEQ_W, where last is the last accepted number on the same virtual link. The frame is accepted when 1 ≤ g < 2^(SEQ_W−1). It is discarded when g = 0 (a duplicate) or when g ≥ 2^(SEQ_W−1) (an older frame).
- R6: The comparison wraps. With SEQ_W=3 and last=7, the numbers 0 through 2 are accepted, and 3 through 7 are discarded.
- R7: When several ports present a frame in the same cycle, only the highest-priority port (A over B over C) is considered, and the frames on the other ports are discarded. This holds even when those frames belong to other virtual links.
- R8: When a frame is missing on one or two networks, the copy that does arrive on another network is delivered. Copies that arrive later on other networks are discarded.
- R9: Each virtual link keeps its own history. Accepting a number on one virtual link does not affect acceptance on any other virtual link.
- R10: `accept_count` increases by one for each delivered frame, in the same cycle in which `rx_valid` is high.
- R11: `discard_count` increases by the number of receive copies dropped in a cycle (0 to 3). Together with `accept_count`, it accounts for every copy presented on the three receive ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Send descriptor valid |
| tx_desc | input | DESC_W | Send frame descriptor |
| tx_ready | output | 1 | Send descriptor taken |
| net_a_tx_valid | output | 1 | Network A send valid |
| net_a_tx_desc | output | DESC_W | Network A send descriptor |
| net_a_tx_ready | input | 1 | Network A send ready |
| net_b_tx_valid | output | 1 | Network B send valid |
| net_b_tx_desc | output | DESC_W | Network B send descriptor |
| net_b_tx_ready | input | 1 | Network B send ready |
| net_c_tx_valid | output | 1 | Network C send valid |
| net_c_tx_desc | output | DESC_W | Network C send descriptor |
| net_c_tx_ready | input | 1 | Network C send ready |
| net_a_rx_valid | input | 1 | Network A receive header valid |
| net_a_rx_vl | input | VL_W | Network A virtual link number |
| net_a_rx_seq | input | SEQ_W | Network A sequence number |
| net_b_rx_valid | input | 1 | Network B receive header valid |
| net_b_rx_vl | input | VL_W | Network B virtual link number |
| net_b_rx_seq | input | SEQ_W | Network B sequence number |
| net_c_rx_valid | input | 1 | Network C receive header valid |
| net_c_rx_vl | input | VL_W | Network C virtual link number |
| net_c_rx_seq | input | SEQ_W | Network C sequence number |
| rx_valid | output | 1 | Delivered frame valid |
| rx_vl | output | VL_W | Delivered virtual link number |
| rx_seq | output | SEQ_W | Delivered sequence number |
| rx_port | output | 2 | Network the delivered copy came from |
| accept_count | output | CNT_W | Delivered frame count |
| discard_count | output | CNT_W | Dropped copy count |

## Verification
The hardest situation to reach from the ports is a specific pair of stored and incoming sequence numbers on one virtual link, especially across the wrap point and at exactly half the number space. The bench reaches it by resetting, planting a chosen first number on a link (always accepted), and then presenting every possible second number. It does this for all 64 pairs in a 3-bit configuration, rotating the arrival network. A long stretch of random simultaneous arrivals across all three networks and four links then checks the priority order and the counter accounting against an arithmetic model.

// File: rtl/trinet_pkg.sv
package trinet_pkg;

  localparam int NET_COUNT = 3;

  typedef enum logic [1:0] {
    NET_A    = 2'd0,
    NET_B    = 2'd1,
    NET_C    = 2'd2,
    NET_NONE = 2'd3
  } net_id_e;

endpackage

// File: rtl/trinet_tx_fanout.sv
module trinet_tx_fanout
  import trinet_pkg::*;
#(
  parameter int DESC_W = 32
) (
  input  logic                              src_valid,
  input  logic [DESC_W-1:0]                 src_desc,
  output logic                              src_ready,
  input  logic [NET_COUNT-1:0]              lane_ready,
  output logic [NET_COUNT-1:0]              lane_valid,
  output logic [NET_COUNT-1:0][DESC_W-1:0]  lane_desc
);

  logic all_ready;
  logic fire;

  assign all_ready = &lane_ready;
  assign src_ready = all_ready;
  assign fire      = src_valid & all_ready;

  for (genvar g = 0; g < NET_COUNT; g++) begin : g_lane
    assign lane_valid[g] = fire;
    assign lane_desc[g]  = src_desc;
  end

endmodule

// File: rtl/trinet_rx_arbiter.sv
module trinet_rx_arbiter
  import trinet_pkg::*;
#(
  parameter int VL_W  = 4,
  parameter int SEQ_W = 8
) (
  input  logic [NET_COUNT-1:0]             in_valid,
  input  logic [NET_COUNT-1:0][VL_W-1:0]   in_vl,
  input  logic [NET_COUNT-1:0][SEQ_W-1:0]  in_seq,
  output logic                             win_valid,
  output net_id_e                          win_net,
  output logic [VL_W-1:0]                  win_vl,
  output logic [SEQ_W-1:0]                 win_seq,
  output logic [1:0]                       lose_cnt
);

  // grant[g] is set for the first valid lane in priority order A, B, C
  logic [NET_COUNT-1:0] grant;
  logic [NET_COUNT:0]   taken;

  assign taken[0] = 1'b0;
  for (genvar g = 0; g < NET_COUNT; g++) begin : g_rank
    assign grant[g]   = in_valid[g] & ~taken[g];
    assign taken[g+1] = taken[g] | in_valid[g];
  end

  assign win_valid = taken[NET_COUNT];

  always_comb begin
    win_net = NET_NONE;
    win_vl  = '0;
    win_seq = '0;
    for (int p = 0; p < NET_COUNT; p++) begin
      if (grant[p]) begin
        win_net = net_id_e'(2'(p));
        win_vl  = in_vl[p];
        win_seq = in_seq[p];
      end
    end
  end

  assign lose_cnt = 2'($countones(in_valid)) - {1'b0, win_valid};

endmodule

// File: rtl/trinet_seq_table.sv
module trinet_seq_table #(
  parameter int VL_W  = 4,
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             look_valid,
  input  logic [VL_W-1:0]  look_vl,
  input  logic [SEQ_W-1:0] look_seq,
  output logic             look_fresh
);

  localparam int NVL = 1 << VL_W;

  logic [NVL-1:0]            seen_q;
  logic [NVL-1:0][SEQ_W-1:0] last_q;

  // Newer-than test under modulo arithmetic: forward gap in the lower half
  function automatic logic seq_is_newer(input logic             has_hist,
                                        input logic [SEQ_W-1:0] prev,
                                        input logic [SEQ_W-1:0] cand);
    logic [SEQ_W-1:0] gap;
    gap = cand - prev;
    return !has_hist || ((gap != '0) && !gap[SEQ_W-1]);
  endfunction

  assign look_fresh = seq_is_newer(seen_q[look_vl], last_q[look_vl], look_seq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      last_q <= '0;
    end else if (look_valid && look_fresh) begin
      seen_q[look_vl] <= 1'b1;
      last_q[look_vl] <= look_seq;
    end
  end

endmodule

// File: rtl/trinet_event_counter.sv
module trinet_event_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       inc,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + CNT_W'(inc);
  end

endmodule

// File: rtl/trinet_redundancy.sv
module trinet_redundancy
  import trinet_pkg::*;
#(
  parameter int DESC_W = 32,
  parameter int VL_W   = 4,
  parameter int SEQ_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [DESC_W-1:0] tx_desc,
  output logic              tx_ready,
  output logic              net_a_tx_valid,
  output logic [DESC_W-1:0] net_a_tx_desc,
  input  logic              net_a_tx_ready,
  output logic              net_b_tx_valid,
  output logic [DESC_W-1:0] net_b_tx_desc,
  input  logic              net_b_tx_ready,
  output logic              net_c_tx_valid,
  output logic [DESC_W-1:0] net_c_tx_desc,
  input  logic              net_c_tx_ready,
  input  logic              net_a_rx_valid,
  input  logic [VL_W-1:0]   net_a_rx_vl,
  input  logic [SEQ_W-1:0]  net_a_rx_seq,
  input  logic              net_b_rx_valid,
  input  logic [VL_W-1:0]   net_b_rx_vl,
  input  logic [SEQ_W-1:0]  net_b_rx_seq,
  input  logic              net_c_rx_valid,
  input  logic [VL_W-1:0]   net_c_rx_vl,
  input  logic [SEQ_W-1:0]  net_c_rx_seq,
  output logic              rx_valid,
  output logic [VL_W-1:0]   rx_vl,
  output logic [SEQ_W-1:0]  rx_seq,
  output logic [1:0]        rx_port,
  output logic [CNT_W-1:0]  accept_count,
  output logic [CNT_W-1:0]  discard_count
);

  // ---------------- send side ----------------
  logic [NET_COUNT-1:0]             lane_ready;
  logic [NET_COUNT-1:0]             lane_valid;
  logic [NET_COUNT-1:0][DESC_W-1:0] lane_desc;

  assign lane_ready = {net_c_tx_ready, net_b_tx_ready, net_a_tx_ready};

  trinet_tx_fanout #(.DESC_W(DESC_W)) u_fanout (
    .src_valid  (tx_valid),
    .src_desc   (tx_desc),
    .src_ready  (tx_ready),
    .lane_ready (lane_ready),
    .lane_valid (lane_valid),
    .lane_desc  (lane_desc)
  );

  assign net_a_tx_valid = lane_valid[0];
  assign net_b_tx_valid = lane_valid[1];
  assign net_c_tx_valid = lane_valid[2];
  assign net_a_tx_desc  = lane_desc[0];
  assign net_b_tx_desc  = lane_desc[1];
  assign net_c_tx_desc  = lane_desc[2];

  // ---------------- receive side ----------------
  logic [NET_COUNT-1:0]            in_valid;
  logic [NET_COUNT-1:0][VL_W-1:0]  in_vl;
  logic [NET_COUNT-1:0][SEQ_W-1:0] in_seq;

  assign in_valid = {net_c_rx_valid, net_b_rx_valid, net_a_rx_valid};
  assign in_vl    = {net_c_rx_vl, net_b_rx_vl, net_a_rx_vl};
  assign in_seq   = {net_c_rx_seq, net_b_rx_seq, net_a_rx_seq};

  logic             win_valid;
  net_id_e          win_net;
  logic [VL_W-1:0]  win_vl;
  logic [SEQ_W-1:0] win_seq;
  logic [1:0]       lose_cnt;
  logic             win_fresh;

  trinet_rx_arbiter #(.VL_W(VL_W), .SEQ_W(SEQ_W)) u_arb (
    .in_valid  (in_valid),
    .in_vl     (in_vl),
    .in_seq    (in_seq),
    .win_valid (win_valid),
    .win_net   (win_net),
    .win_vl    (win_vl),
    .win_seq   (win_seq),
    .lose_cnt  (lose_cnt)
  );

  trinet_seq_table #(.VL_W(VL_W), .SEQ_W(SEQ_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_valid (win_valid),
    .look_vl    (win_vl),
    .look_seq   (win_seq),
    .look_fresh (win_fresh)
  );

  // Named events for the checker
  logic       accept_evt;
  logic       stale_evt;
  logic [1:0] drop_inc;

  assign accept_evt = win_valid & win_fresh;
  assign stale_evt  = win_valid & ~win_fresh;
  assign drop_inc   = lose_cnt + {1'b0, stale_evt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_vl    <= '0;
      rx_seq   <= '0;
      rx_port  <= NET_NONE;
    end else begin
      rx_valid <= accept_evt;
      if (accept_evt) begin
        rx_vl   <= win_vl;
        rx_seq  <= win_seq;
        rx_port <= win_net;
      end
    end
  end

  trinet_event_counter #(.CNT_W(CNT_W)) u_acc_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   ({1'b0, accept_evt}),
    .count (accept_count)
  );

  trinet_event_counter #(.CNT_W(CNT_W)) u_drop_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (drop_inc),
    .count (discard_count)
  );

endmodule

// File: rtl/trinet_redundancy_chk.sv
module trinet_redundancy_chk #(
  parameter int DESC_W = 32,
  parameter int VL_W   = 4,
  parameter int SEQ_W  = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DESC_W-1:0] tx_desc,
  input logic              net_a_tx_valid,
  input logic              net_b_tx_valid,
  input logic              net_c_tx_valid,
  input logic [DESC_W-1:0] net_a_tx_desc,
  input logic [DESC_W-1:0] net_b_tx_desc,
  input logic [DESC_W-1:0] net_c_tx_desc,
  input logic              net_a_tx_ready,
  input logic              net_b_tx_ready,
  input logic              net_c_tx_ready,
  input logic              net_a_rx_valid,
  input logic              net_b_rx_valid,
  input logic              net_c_rx_valid,
  input logic              rx_valid,
  input logic [VL_W-1:0]   rx_vl,
  input logic [SEQ_W-1:0]  rx_seq,
  input logic [1:0]        rx_port,
  input logic [CNT_W-1:0]  accept_count,
  input logic [CNT_W-1:0]  discard_count
);

  logic [2:0]       rx_any;
  logic [CNT_W-1:0] total_count;

  assign rx_any      = {net_c_rx_valid, net_b_rx_valid, net_a_rx_valid};
  assign total_count = accept_count + discard_count;

  p_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(net_a_tx_ready && net_b_tx_ready && net_c_tx_ready) |-> !tx_ready && !net_a_tx_valid);

  p_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
    net_a_tx_valid |-> net_b_tx_valid && net_c_tx_valid && tx_valid &&
                       net_a_tx_desc == tx_desc && net_b_tx_desc == tx_desc &&
                       net_c_tx_desc == tx_desc);

  p_out_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_any) != 3'b000);

  p_no_repeat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && $past(rx_valid) && rx_vl == $past(rx_vl) |-> rx_seq != $past(rx_seq));

  p_prio_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    net_a_rx_valid |=> !rx_valid || rx_port == 2'd0);

  p_acc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> accept_count == $past(accept_count) + CNT_W'(rx_valid));

  p_account_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> total_count == $past(total_count) + CNT_W'($countones($past(rx_any))));

endmodule

bind trinet_redundancy trinet_redundancy_chk #(
  .DESC_W(DESC_W), .VL_W(VL_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tx_valid       (tx_valid),
  .tx_ready       (tx_ready),
  .tx_desc        (tx_desc),
  .net_a_tx_valid (net_a_tx_valid),
  .net_b_tx_valid (net_b_tx_valid),
  .net_c_tx_valid (net_c_tx_valid),
  .net_a_tx_desc  (net_a_tx_desc),
  .net_b_tx_desc  (net_b_tx_desc),
  .net_c_tx_desc  (net_c_tx_desc),
  .net_a_tx_ready (net_a_tx_ready),
  .net_b_tx_ready (net_b_tx_ready),
  .net_c_tx_ready (net_c_tx_ready),
  .net_a_rx_valid (net_a_rx_valid),
  .net_b_rx_valid (net_b_rx_valid),
  .net_c_rx_valid (net_c_rx_valid),
  .rx_valid       (rx_valid),
  .rx_vl          (rx_vl),
  .rx_seq         (rx_seq),
  .rx_port        (rx_port),
  .accept_count   (accept_count),
  .discard_count  (discard_count)
);

// File: tb/test_trinet_redundancy.sv
module test_trinet_redundancy;

  localparam int CLK_PERIOD = 10;
  localparam int DESC_W = 8;
  localparam int VL_W   = 2;
  localparam int SEQ_W  = 3;
  localparam int CNT_W  = 12;
  localparam int NVL    = 4;
  localparam int NSEQ   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid = 1'b0;
  logic [DESC_W-1:0] tx_desc = '0;
  logic tx_ready;
  logic a_txv, b_txv, c_txv;
  logic [DESC_W-1:0] a_txd, b_txd, c_txd;
  logic a_txr = 1'b0, b_txr = 1'b0, c_txr = 1'b0;
  logic a_rv = 1'b0, b_rv = 1'b0, c_rv = 1'b0;
  logic [VL_W-1:0] a_vl = '0, b_vl = '0, c_vl = '0;
  logic [SEQ_W-1:0] a_sq = '0, b_sq = '0, c_sq = '0;
  logic rx_valid;
  logic [VL_W-1:0] rx_vl;
  logic [SEQ_W-1:0] rx_seq;
  logic [1:0] rx_port;
  logic [CNT_W-1:0] accept_count, discard_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  trinet_redundancy #(.DESC_W(DESC_W), .VL_W(VL_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) i_trinet_redundancy (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_desc(tx_desc), .tx_ready(tx_ready),
    .net_a_tx_valid(a_txv), .net_a_tx_desc(a_txd), .net_a_tx_ready(a_txr),
    .net_b_tx_valid(b_txv), .net_b_tx_desc(b_txd), .net_b_tx_ready(b_txr),
    .net_c_tx_valid(c_txv), .net_c_tx_desc(c_txd), .net_c_tx_ready(c_txr),
    .net_a_rx_valid(a_rv), .net_a_rx_vl(a_vl), .net_a_rx_seq(a_sq),
    .net_b_rx_valid(b_rv), .net_b_rx_vl(b_vl), .net_b_rx_seq(b_sq),
    .net_c_rx_valid(c_rv), .net_c_rx_vl(c_vl), .net_c_rx_seq(c_sq),
    .rx_valid(rx_valid), .rx_vl(rx_vl), .rx_seq(rx_seq), .rx_port(rx_port),
    .accept_count(accept_count), .discard_count(discard_count)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Bench model of per-link history
  int  m_last [NVL];
  bit  m_seen [NVL];
  int  m_acc = 0;
  int  m_drop = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  task automatic do_reset();
    a_rv = 0; b_rv = 0; c_rv = 0;
    rst_n = 0;
    @(posedge clk); @(posedge clk);
    #1 rst_n = 1;
    for (int v = 0; v < NVL; v++) begin m_last[v] = 0; m_seen[v] = 0; end
    m_acc = 0; m_drop = 0;
  endtask

  // Accept rule restated: forward distance 1..NSEQ/2-1, or no history
  function automatic bit model_take(int v, int s);
    int d;
    if (!m_seen[v]) return 1;
    d = (s + NSEQ - m_last[v]) % NSEQ;
    return d > 0 && d < NSEQ / 2;
  endfunction

  // Present one cycle of receive headers, then check the registered result
  task automatic step(input bit va, input int vla, input int sa,
                      input bit vb, input int vlb, input int sb,
                      input bit vc, input int vlc, input int sc,
                      input string tag);
    int w, wv, ws, n;
    bit exp_out;
    a_rv = va; a_vl = VL_W'(vla); a_sq = SEQ_W'(sa);
    b_rv = vb; b_vl = VL_W'(vlb); b_sq = SEQ_W'(sb);
    c_rv = vc; c_vl = VL_W'(vlc); c_sq = SEQ_W'(sc);
    n = int'(va) + int'(vb) + int'(vc);
    w = va ? 0 : (vb ? 1 : (vc ? 2 : -1));
    wv = (w == 0) ? vla : (w == 1) ? vlb : vlc;
    ws = (w == 0) ? sa  : (w == 1) ? sb  : sc;
    exp_out = 0;
    if (w >= 0) begin
      if (model_take(wv, ws)) begin
        exp_out = 1; m_seen[wv] = 1; m_last[wv] = ws; m_acc++;
        m_drop += n - 1;
      end else begin
        m_drop += n;
      end
    end
    @(posedge clk);
    #1;
    chk({tag, " rx_valid"}, int'(rx_valid), int'(exp_out));
    if (exp_out) begin
      chk({tag, " rx_vl"},   int'(rx_vl),   wv);
      chk({tag, " rx_seq"},  int'(rx_seq),  ws);
      chk({tag, " rx_port"}, int'(rx_port), w);
    end
    chk({tag, " accept_count R10"},  int'(accept_count),  m_acc % (1 << CNT_W));
    chk({tag, " discard_count R11"}, int'(discard_count), m_drop % (1 << CNT_W));
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    do_reset();
    // R3: reset state
    chk("R3 rx_valid after reset", int'(rx_valid), 0);
    chk("R3 accept_count after reset", int'(accept_count), 0);
    chk("R3 discard_count after reset", int'(discard_count), 0);

    // R1 / R2: every ready pattern with and without a descriptor
    for (int r = 0; r < 8; r++) begin
      for (int v = 0; v < 2; v++) begin
        bit all;
        bit fire;
        a_txr = r[0]; b_txr = r[1]; c_txr = r[2];
        tx_valid = v[0];
        tx_desc = DESC_W'(r * 16 + v * 5 + 3);
        #1;
        all = (r == 7);
        fire = all && (v == 1);
        chk("R1 tx_ready", int'(tx_ready), int'(all));
        chk("R2 net A valid", int'(a_txv), int'(fire));
        chk("R2 net B valid", int'(b_txv), int'(fire));
        chk("R2 net C valid", int'(c_txv), int'(fire));
        if (fire) begin
          chk("R2 net A desc", int'(a_txd), r * 16 + v * 5 + 3);
          chk("R2 net B desc", int'(b_txd), r * 16 + v * 5 + 3);
          chk("R2 net C desc", int'(c_txd), r * 16 + v * 5 + 3);
        end
        @(negedge clk);
      end
    end
    tx_valid = 0;

    // R5 / R6: every (last, new) pair on one link, arrival network rotating
    for (int l = 0; l < NSEQ; l++) begin
      for (int s = 0; s < NSEQ; s++) begin
        int p;
        int v;
        p = (l + s) % 3;
        v = (l + s) % NVL;
        do_reset();
        step(p == 0, v, l, p == 1, v, l, p == 2, v, l, "R3 first frame");
        if (s < l) step(p == 2, v, s, p == 0, v, s, p == 1, v, s, "R6 wrap pair");
        else       step(p == 2, v, s, p == 0, v, s, p == 1, v, s, "R5 seq pair");
      end
    end

    // R8: staggered copies and a loss on network A
    do_reset();
    step(1, 1, 4, 0, 0, 0, 0, 0, 0, "R8 first copy on A");
    step(0, 0, 0, 1, 1, 4, 0, 0, 0, "R8 late copy on B");
    step(0, 0, 0, 0, 0, 0, 1, 1, 4, "R8 late copy on C");
    step(0, 0, 0, 1, 1, 5, 1, 1, 5, "R8 A lost, B wins");
    step(0, 0, 0, 0, 0, 0, 1, 1, 6, "R8 A and B lost, C delivers");
    step(1, 1, 6, 1, 1, 6, 0, 0, 0, "R8 copies after C");

    // R7: same-cycle arrivals on different links, only A considered
    step(1, 2, 1, 1, 3, 1, 1, 0, 1, "R7 three links same cycle");
    step(0, 0, 0, 0, 0, 0, 1, 3, 1, "R7 loser link still fresh");
    step(1, 2, 1, 1, 0, 2, 0, 0, 0, "R7 stale A blocks fresh B");

    // R9: independent histories
    step(1, 0, 7, 0, 0, 0, 0, 0, 0, "R9 link0");
    step(0, 0, 0, 1, 1, 7, 0, 0, 0, "R9 link1 unaffected");
    step(0, 0, 0, 0, 0, 0, 1, 0, 7, "R9 link0 repeat");
    idle("R4 idle cycle");

    // R11: random arrivals over all networks and links
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom);
      step(r[0], r[3:2], r[6:4], r[1], r[8:7], r[11:9], r[12], r[14:13], r[17:15], "R11 random");
    end
    idle("R4 final idle");

    finish_run();
  end

endmodule